// File: doc/BRIEF.md
# Miss Status Holding Register File

This block keeps track of the read misses that are still outstanding in one cache bank. Each of its entries stores one missed request: the set index, the line tag, a write flag, a per-port record of which requester is waiting and under which core tag, and the victim way chosen for the coming line fill. Every entry is in one of three states: free, waiting for memory, or ready to be replayed.

The miss path asks the block each cycle whether a miss to the same line is already in flight. It issues a memory read only when the answer is no. Whether or not it issues a read, it allocates an entry. The allocated entry index goes out as the tag of the memory read. When memory answers, its response carries that index back to the block. The block then moves every entry waiting on the same set and tag to the replay-ready state in a single cycle, and it presents the root entry's set, tag and way so the tag array can be updated. The pipeline then drains the replay-ready entries one per cycle through the pop port. A clear input returns the whole file to the empty state.

Allocation, fill and pop results, the full flag and the occupancy count all come from registers. The lookup answer is combinational, from the stored entries.

Top module: `mshr_file`

## Requirements
- R1: After reset or after a cycle with `clr_i` high, `count_o` is 0, `full_o` is 0, `lk_hit_o` is 0 for any query, and no acknowledge, update or replay output is valid.
- R2: `lk_hit_o` is 1 when at least one entry that is waiting or replay-ready holds the queried set and tag. It is 0 when only the set or only the tag matches.
- R3: An allocation request that is accepted takes the lowest-index free entry. In the next cycle `al_ack_o` is 1, `al_idx_o` gives that index, and `count_o` has gone up by one.
- R4: `full_o` is 1 exactly when `count_o` equals the number of entries. An allocation request made while the file is full is ignored: no acknowledge and no change in count.
- R5: A fill whose indexed entry is waiting moves every waiting entry with the same set and tag to replay-ready. In the next cycle it presents the root entry's set, tag and way on `up_*_o` with `up_valid_o` high. Waiting entries for other lines stay waiting.
- R6: A fill whose indexed entry is free or already replay-ready is ignored. No update is presented and no entry changes state.
- R7: A pop returns the lowest-index replay-ready entry in the next cycle with `rp_valid_o` high, together with its set, tag, write flag, port valid bits, requester ids and core tags. That entry becomes free and `count_o` goes down by one. At most one entry leaves per cycle, and an entry made replay-ready in the same cycle as the pop is not eligible.
- R8: A pop while no entry is replay-ready produces no valid replay output and leaves the count unchanged.
- R9: When an allocation and a pop are both accepted in one cycle, `count_o` is unchanged. The allocation chooses among the entries that were free before the pop. `clr_i` overrides any allocation, fill or pop in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| clr_i | input | 1 | Frees every entry |
| lk_set_i | input | SET_W | Set index queried for an outstanding miss |
| lk_tag_i | input | TAG_W | Line tag queried for an outstanding miss |
| lk_hit_o | output | 1 | An occupied entry matches the query |
| al_valid_i | input | 1 | Allocation request |
| al_set_i | input | SET_W | Set index of the missed request |
| al_tag_i | input | TAG_W | Line tag of the missed request |
| al_write_i | input | 1 | The missed request is a write |
| al_pvld_i | input | NUM_PORTS | Ports that carry a requester |
| al_pid_i | input | NUM_PORTS x REQID_W | Requester id per port |
| al_ptag_i | input | NUM_PORTS x CTAG_W | Core tag per port |
| al_way_i | input | WAY_W | Victim way for the fill |
| al_ack_o | output | 1 | Allocation accepted in the previous cycle |
| al_idx_o | output | IDX_W | Entry index given to that allocation |
| fl_valid_i | input | 1 | Memory fill arrived |
| fl_idx_i | input | IDX_W | Entry index returned with the fill |
| up_valid_o | output | 1 | Line update valid |
| up_set_o | output | SET_W | Set of the line to update |
| up_tag_o | output | TAG_W | Tag of the line to update |
| up_way_o | output | WAY_W | Way of the line to update |
| pop_i | input | 1 | Request to drain one replay-ready entry |
| rp_valid_o | output | 1 | Replay record valid |
| rp_set_o | output | SET_W | Replayed set index |
| rp_tag_o | output | TAG_W | Replayed line tag |
| rp_write_o | output | 1 | Replayed write flag |
| rp_pvld_o | output | NUM_PORTS | Replayed port valid bits |
| rp_pid_o | output | NUM_PORTS x REQID_W | Replayed requester ids |
| rp_ptag_o | output | NUM_PORTS x CTAG_W | Replayed core tags |
| full_o | output | 1 | Every entry occupied |
| count_o | output | CNT_W | Number of occupied entries |

## Verification
The bench builds the file with four entries, two ports, three-bit set indices and six-bit tags. With four entries, four allocations fill it, so the full flag and an allocation refused while full are reached early. That leaves room for two entries that share one line and a third entry that shares only the tag with them, which shows that a fill releases exactly the matching waiting entries. The small size also makes reuse of freed slots and the lowest-index choice visible after pops and alongside an allocation in the same cycle. Same-cycle combinations of fill with pop, and of clear with allocation, are driven on purpose.

// File: rtl/mshr_file_pkg.sv
package mshr_file_pkg;

  // Life cycle of one miss entry.
  typedef enum logic [1:0] {
    ENT_FREE = 2'd0,
    ENT_WAIT = 2'd1,
    ENT_RPLY = 2'd2
  } ent_state_e;

endpackage

// File: rtl/mshr_first_set.sv
// Lowest-index set bit of a request vector.
module mshr_first_set #(
  parameter int N     = 8,
  parameter int IDX_W = 3
) (
  input  logic [N-1:0]     vec_i,
  output logic             found_o,
  output logic [IDX_W-1:0] idx_o
);

  always_comb begin
    found_o = |vec_i;
    idx_o   = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (vec_i[i]) idx_o = IDX_W'(i);
    end
  end

endmodule

// File: rtl/mshr_line_match.sv
// Parallel set/tag comparison against every entry, masked by a liveness vector.
module mshr_line_match #(
  parameter int N     = 8,
  parameter int SET_W = 6,
  parameter int TAG_W = 20
) (
  input  logic [N-1:0][SET_W-1:0] ent_set_i,
  input  logic [N-1:0][TAG_W-1:0] ent_tag_i,
  input  logic [N-1:0]            live_i,
  input  logic [SET_W-1:0]        q_set_i,
  input  logic [TAG_W-1:0]        q_tag_i,
  output logic [N-1:0]            hit_o
);

  for (genvar g = 0; g < N; g++) begin : g_cmp
    assign hit_o[g] = live_i[g]
                    && (ent_set_i[g] == q_set_i)
                    && (ent_tag_i[g] == q_tag_i);
  end

endmodule

// File: rtl/mshr_payload_ram.sv
// One write port, one registered read port; no reset on the array so it can map to RAM.
module mshr_payload_ram #(
  parameter int DEPTH = 8,
  parameter int WIDTH = 32,
  parameter int AW    = 3
) (
  input  logic             clk,
  input  logic             we_i,
  input  logic [AW-1:0]    waddr_i,
  input  logic [WIDTH-1:0] wdata_i,
  input  logic             re_i,
  input  logic [AW-1:0]    raddr_i,
  output logic [WIDTH-1:0] rdata_o
);

  logic [WIDTH-1:0] mem [DEPTH];
  logic [WIDTH-1:0] rdata_q;

  always_ff @(posedge clk) begin
    if (we_i) mem[waddr_i] <= wdata_i;
  end

  always_ff @(posedge clk) begin
    if (re_i) rdata_q <= mem[raddr_i];
  end

  assign rdata_o = rdata_q;

endmodule

// File: rtl/mshr_file.sv
module mshr_file
  import mshr_file_pkg::*;
#(
  parameter int NUM_ENTRIES = 8,
  parameter int SET_W       = 6,
  parameter int TAG_W       = 20,
  parameter int WAY_W       = 2,
  parameter int NUM_PORTS   = 4,
  parameter int REQID_W     = 4,
  parameter int CTAG_W      = 8,
  localparam int IDX_W      = (NUM_ENTRIES > 1) ? $clog2(NUM_ENTRIES) : 1,
  localparam int CNT_W      = $clog2(NUM_ENTRIES + 1)
) (
  input  logic                              clk,
  input  logic                              rst,
  input  logic                              clr_i,
  input  logic [SET_W-1:0]                  lk_set_i,
  input  logic [TAG_W-1:0]                  lk_tag_i,
  output logic                              lk_hit_o,
  input  logic                              al_valid_i,
  input  logic [SET_W-1:0]                  al_set_i,
  input  logic [TAG_W-1:0]                  al_tag_i,
  input  logic                              al_write_i,
  input  logic [NUM_PORTS-1:0]              al_pvld_i,
  input  logic [NUM_PORTS-1:0][REQID_W-1:0] al_pid_i,
  input  logic [NUM_PORTS-1:0][CTAG_W-1:0]  al_ptag_i,
  input  logic [WAY_W-1:0]                  al_way_i,
  output logic                              al_ack_o,
  output logic [IDX_W-1:0]                  al_idx_o,
  input  logic                              fl_valid_i,
  input  logic [IDX_W-1:0]                  fl_idx_i,
  output logic                              up_valid_o,
  output logic [SET_W-1:0]                  up_set_o,
  output logic [TAG_W-1:0]                  up_tag_o,
  output logic [WAY_W-1:0]                  up_way_o,
  input  logic                              pop_i,
  output logic                              rp_valid_o,
  output logic [SET_W-1:0]                  rp_set_o,
  output logic [TAG_W-1:0]                  rp_tag_o,
  output logic                              rp_write_o,
  output logic [NUM_PORTS-1:0]              rp_pvld_o,
  output logic [NUM_PORTS-1:0][REQID_W-1:0] rp_pid_o,
  output logic [NUM_PORTS-1:0][CTAG_W-1:0]  rp_ptag_o,
  output logic                              full_o,
  output logic [CNT_W-1:0]                  count_o
);

  localparam int PAY_W = 1 + NUM_PORTS * (1 + REQID_W + CTAG_W);

  // Entry state and the fields that must be compared in parallel live in flops.
  ent_state_e                         st_q [NUM_ENTRIES];
  logic [NUM_ENTRIES-1:0][SET_W-1:0]  set_q;
  logic [NUM_ENTRIES-1:0][TAG_W-1:0]  tag_q;
  logic [NUM_ENTRIES-1:0][WAY_W-1:0]  way_q;
  logic [CNT_W-1:0]                   cnt_q;
  logic                               full_q;

  logic [NUM_ENTRIES-1:0] free_vec, wait_vec, rdy_vec, live_vec;
  logic [NUM_ENTRIES-1:0] lk_vec, fl_vec;

  always_comb begin
    for (int i = 0; i < NUM_ENTRIES; i++) begin
      free_vec[i] = (st_q[i] == ENT_FREE);
      wait_vec[i] = (st_q[i] == ENT_WAIT);
      rdy_vec[i]  = (st_q[i] == ENT_RPLY);
    end
    live_vec = ~free_vec;
  end

  // Slot choice for allocation and for replay drain.
  logic             free_found, rdy_found;
  logic [IDX_W-1:0] free_idx, rdy_idx;

  mshr_first_set #(.N(NUM_ENTRIES), .IDX_W(IDX_W)) u_pick_free (
    .vec_i   (free_vec),
    .found_o (free_found),
    .idx_o   (free_idx)
  );

  mshr_first_set #(.N(NUM_ENTRIES), .IDX_W(IDX_W)) u_pick_rdy (
    .vec_i   (rdy_vec),
    .found_o (rdy_found),
    .idx_o   (rdy_idx)
  );

  // Outstanding-miss query from the bank pipeline.
  mshr_line_match #(.N(NUM_ENTRIES), .SET_W(SET_W), .TAG_W(TAG_W)) u_lookup (
    .ent_set_i (set_q),
    .ent_tag_i (tag_q),
    .live_i    (live_vec),
    .q_set_i   (lk_set_i),
    .q_tag_i   (lk_tag_i),
    .hit_o     (lk_vec)
  );

  assign lk_hit_o = |lk_vec;

  // Fill: root entry fields, then release of every waiter on the same line.
  logic             fl_in_range;
  logic             root_wait;
  logic [SET_W-1:0] root_set;
  logic [TAG_W-1:0] root_tag;
  logic [WAY_W-1:0] root_way;

  assign fl_in_range = (int'(fl_idx_i) < NUM_ENTRIES);
  assign root_set    = set_q[fl_idx_i];
  assign root_tag    = tag_q[fl_idx_i];
  assign root_way    = way_q[fl_idx_i];
  assign root_wait   = fl_in_range && wait_vec[fl_idx_i];

  mshr_line_match #(.N(NUM_ENTRIES), .SET_W(SET_W), .TAG_W(TAG_W)) u_release (
    .ent_set_i (set_q),
    .ent_tag_i (tag_q),
    .live_i    (wait_vec),
    .q_set_i   (root_set),
    .q_tag_i   (root_tag),
    .hit_o     (fl_vec)
  );

  // Accepted operations this cycle; clear overrides all of them.
  logic alloc_fire, pop_fire, fill_ok;

  assign alloc_fire = al_valid_i && free_found && !clr_i;
  assign pop_fire   = pop_i && rdy_found && !clr_i;
  assign fill_ok    = fl_valid_i && root_wait && !clr_i;

  // State transitions: pop frees, fill releases, allocation claims.
  always_ff @(posedge clk) begin
    if (rst || clr_i) begin
      for (int i = 0; i < NUM_ENTRIES; i++) st_q[i] <= ENT_FREE;
    end else begin
      for (int i = 0; i < NUM_ENTRIES; i++) begin
        if (pop_fire && (rdy_idx == IDX_W'(i))) begin
          st_q[i] <= ENT_FREE;
        end else if (fill_ok && fl_vec[i]) begin
          st_q[i] <= ENT_RPLY;
        end else if (alloc_fire && (free_idx == IDX_W'(i))) begin
          st_q[i] <= ENT_WAIT;
        end
      end
    end
  end

  // Line identity and victim way of each entry.
  always_ff @(posedge clk) begin
    if (alloc_fire) begin
      set_q[free_idx] <= al_set_i;
      tag_q[free_idx] <= al_tag_i;
      way_q[free_idx] <= al_way_i;
    end
  end

  // Occupancy and full flag, both registered.
  logic [CNT_W-1:0] cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (alloc_fire) cnt_d = cnt_d + CNT_W'(1);
    if (pop_fire)   cnt_d = cnt_d - CNT_W'(1);
  end

  always_ff @(posedge clk) begin
    if (rst || clr_i) begin
      cnt_q  <= '0;
      full_q <= 1'b0;
    end else begin
      cnt_q  <= cnt_d;
      full_q <= (cnt_d == CNT_W'(NUM_ENTRIES));
    end
  end

  assign count_o = cnt_q;
  assign full_o  = full_q;

  // Requester payload lives in RAM; only the drain path reads it.
  logic [PAY_W-1:0] pay_wr, pay_rd;

  assign pay_wr = {al_write_i, al_pvld_i, al_pid_i, al_ptag_i};

  mshr_payload_ram #(.DEPTH(NUM_ENTRIES), .WIDTH(PAY_W), .AW(IDX_W)) u_payload (
    .clk     (clk),
    .we_i    (alloc_fire),
    .waddr_i (free_idx),
    .wdata_i (pay_wr),
    .re_i    (pop_fire),
    .raddr_i (rdy_idx),
    .rdata_o (pay_rd)
  );

  assign {rp_write_o, rp_pvld_o, rp_pid_o, rp_ptag_o} = pay_rd;

  // Registered result ports.
  logic             ack_q, upv_q, rpv_q;
  logic [IDX_W-1:0] aidx_q;
  logic [SET_W-1:0] upset_q, rpset_q;
  logic [TAG_W-1:0] uptag_q, rptag_q;
  logic [WAY_W-1:0] upway_q;

  always_ff @(posedge clk) begin
    if (rst || clr_i) begin
      ack_q <= 1'b0;
      upv_q <= 1'b0;
      rpv_q <= 1'b0;
    end else begin
      ack_q <= alloc_fire;
      upv_q <= fill_ok;
      rpv_q <= pop_fire;
    end
  end

  always_ff @(posedge clk) begin
    if (alloc_fire) aidx_q <= free_idx;
    if (fill_ok) begin
      upset_q <= root_set;
      uptag_q <= root_tag;
      upway_q <= root_way;
    end
    if (pop_fire) begin
      rpset_q <= set_q[rdy_idx];
      rptag_q <= tag_q[rdy_idx];
    end
  end

  assign al_ack_o   = ack_q;
  assign al_idx_o   = aidx_q;
  assign up_valid_o = upv_q;
  assign up_set_o   = upset_q;
  assign up_tag_o   = uptag_q;
  assign up_way_o   = upway_q;
  assign rp_valid_o = rpv_q;
  assign rp_set_o   = rpset_q;
  assign rp_tag_o   = rptag_q;

endmodule

// File: rtl/mshr_file_chk.sv
module mshr_file_chk #(
  parameter int NUM_ENTRIES = 8,
  localparam int CNT_W      = $clog2(NUM_ENTRIES + 1)
) (
  input logic             clk,
  input logic             rst,
  input logic             clr_i,
  input logic             lk_hit_o,
  input logic             al_valid_i,
  input logic             al_ack_o,
  input logic             fl_valid_i,
  input logic             up_valid_o,
  input logic             pop_i,
  input logic             rp_valid_o,
  input logic             full_o,
  input logic [CNT_W-1:0] count_o
);

  AST_CLEAR_EMPTIES: assert property (@(posedge clk) disable iff (rst)
    clr_i |=> (count_o == '0) && !full_o && !lk_hit_o && !al_ack_o && !up_valid_o && !rp_valid_o); // R1

  AST_EMPTY_NO_HIT: assert property (@(posedge clk) disable iff (rst)
    (count_o == '0) |-> !lk_hit_o); // R2

  AST_ALLOC_TAKEN: assert property (@(posedge clk) disable iff (rst)
    (al_valid_i && !full_o && !clr_i) |=> al_ack_o); // R3

  AST_FULL_FLAG: assert property (@(posedge clk) disable iff (rst)
    full_o == (int'(count_o) == NUM_ENTRIES)); // R4

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (rst)
    int'(count_o) <= NUM_ENTRIES); // R4

  AST_FULL_REFUSES: assert property (@(posedge clk) disable iff (rst)
    (full_o && al_valid_i) |=> !al_ack_o); // R4

  AST_UPDATE_CAUSED: assert property (@(posedge clk) disable iff (rst)
    up_valid_o |-> $past(fl_valid_i)); // R5

  AST_REPLAY_CAUSED: assert property (@(posedge clk) disable iff (rst)
    rp_valid_o |-> $past(pop_i)); // R7

  AST_COUNT_BALANCE: assert property (@(posedge clk) disable iff (rst)
    !clr_i |=> (int'(count_o) + int'(rp_valid_o) == int'($past(count_o)) + int'(al_ack_o))); // R9

endmodule

bind mshr_file mshr_file_chk #(.NUM_ENTRIES(NUM_ENTRIES)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .clr_i      (clr_i),
  .lk_hit_o   (lk_hit_o),
  .al_valid_i (al_valid_i),
  .al_ack_o   (al_ack_o),
  .fl_valid_i (fl_valid_i),
  .up_valid_o (up_valid_o),
  .pop_i      (pop_i),
  .rp_valid_o (rp_valid_o),
  .full_o     (full_o),
  .count_o    (count_o)
);

// File: tb/mshr_file_tb.sv
module mshr_file_tb;

  localparam int CLK_PERIOD = 10;
  localparam int N   = 4;
  localparam int SW  = 3;
  localparam int TW  = 6;
  localparam int WW  = 2;
  localparam int NP  = 2;
  localparam int IW  = 3;
  localparam int CW  = 4;
  localparam int XW  = 2;
  localparam int KW  = 3;
  localparam int PW  = 1 + NP * (1 + IW + CW);

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #(CLK_PERIOD / 2) clk = ~clk;

  logic                   clr_i = 0;
  logic [SW-1:0]          lk_set_i = '0;
  logic [TW-1:0]          lk_tag_i = '0;
  logic                   lk_hit_o;
  logic                   al_valid_i = 0;
  logic [SW-1:0]          al_set_i = '0;
  logic [TW-1:0]          al_tag_i = '0;
  logic                   al_write_i = 0;
  logic [NP-1:0]          al_pvld_i = '0;
  logic [NP-1:0][IW-1:0]  al_pid_i = '0;
  logic [NP-1:0][CW-1:0]  al_ptag_i = '0;
  logic [WW-1:0]          al_way_i = '0;
  logic                   al_ack_o;
  logic [XW-1:0]          al_idx_o;
  logic                   fl_valid_i = 0;
  logic [XW-1:0]          fl_idx_i = '0;
  logic                   up_valid_o;
  logic [SW-1:0]          up_set_o;
  logic [TW-1:0]          up_tag_o;
  logic [WW-1:0]          up_way_o;
  logic                   pop_i = 0;
  logic                   rp_valid_o;
  logic [SW-1:0]          rp_set_o;
  logic [TW-1:0]          rp_tag_o;
  logic                   rp_write_o;
  logic [NP-1:0]          rp_pvld_o;
  logic [NP-1:0][IW-1:0]  rp_pid_o;
  logic [NP-1:0][CW-1:0]  rp_ptag_o;
  logic                   full_o;
  logic [KW-1:0]          count_o;

  mshr_file #(
    .NUM_ENTRIES(N), .SET_W(SW), .TAG_W(TW), .WAY_W(WW),
    .NUM_PORTS(NP), .REQID_W(IW), .CTAG_W(CW)
  ) u_dut (
    .clk, .rst, .clr_i, .lk_set_i, .lk_tag_i, .lk_hit_o,
    .al_valid_i, .al_set_i, .al_tag_i, .al_write_i, .al_pvld_i, .al_pid_i,
    .al_ptag_i, .al_way_i, .al_ack_o, .al_idx_o, .fl_valid_i, .fl_idx_i,
    .up_valid_o, .up_set_o, .up_tag_o, .up_way_o, .pop_i, .rp_valid_o,
    .rp_set_o, .rp_tag_o, .rp_write_o, .rp_pvld_o, .rp_pid_o, .rp_ptag_o,
    .full_o, .count_o
  );

  int n_chk  = 0;
  int n_fail = 0;

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // Reference model built from the requirements (0 free, 1 waiting, 2 replay-ready).
  int              m_st  [N];
  logic [SW-1:0]   m_set [N];
  logic [TW-1:0]   m_tag [N];
  logic [WW-1:0]   m_way [N];
  logic [PW-1:0]   m_pay [N];
  int              m_cnt = 0;

  int                        q_al [$];
  logic [SW+TW+WW-1:0]       q_up [$];
  logic [SW+TW+PW-1:0]       q_rp [$];

  initial for (int i = 0; i < N; i++) m_st[i] = 0;

  // Driver: one cycle of stimulus, model update and expectation push.
  task automatic op(input logic av, input logic [SW-1:0] as, input logic [TW-1:0] at,
                    input logic aw, input logic [NP-1:0] apv,
                    input logic [NP-1:0][IW-1:0] api, input logic [NP-1:0][CW-1:0] apt,
                    input logic [WW-1:0] away, input logic fv, input logic [XW-1:0] fi,
                    input logic pp, input logic cl);
    int  fr;
    int  rd;
    int  nst [N];
    @(negedge clk);
    al_valid_i = av; al_set_i = as; al_tag_i = at; al_write_i = aw;
    al_pvld_i = apv; al_pid_i = api; al_ptag_i = apt; al_way_i = away;
    fl_valid_i = fv; fl_idx_i = fi; pop_i = pp; clr_i = cl;
    if (cl) begin
      for (int i = 0; i < N; i++) m_st[i] = 0;
      m_cnt = 0;
    end else begin
      fr = -1; rd = -1;
      for (int i = N - 1; i >= 0; i--) begin
        if (m_st[i] == 0) fr = i;
        if (m_st[i] == 2) rd = i;
      end
      for (int i = 0; i < N; i++) nst[i] = m_st[i];
      if (pp && rd >= 0) begin
        q_rp.push_back({m_set[rd], m_tag[rd], m_pay[rd]});
        nst[rd] = 0;
        m_cnt--;
      end
      if (fv && m_st[fi] == 1) begin
        q_up.push_back({m_set[fi], m_tag[fi], m_way[fi]});
        for (int i = 0; i < N; i++)
          if (m_st[i] == 1 && m_set[i] == m_set[fi] && m_tag[i] == m_tag[fi]) nst[i] = 2;
      end
      if (av && fr >= 0) begin
        q_al.push_back(fr);
        nst[fr] = 1;
        m_set[fr] = as; m_tag[fr] = at; m_way[fr] = away;
        m_pay[fr] = {aw, apv, api, apt};
        m_cnt++;
      end
      for (int i = 0; i < N; i++) m_st[i] = nst[i];
    end
    @(posedge clk);
    #1;
    al_valid_i = 0; fl_valid_i = 0; pop_i = 0; clr_i = 0;
  endtask

  task automatic alloc(input logic [SW-1:0] s, input logic [TW-1:0] t, input logic w,
                       input logic [NP-1:0] pv, input logic [NP-1:0][IW-1:0] pi,
                       input logic [NP-1:0][CW-1:0] pt, input logic [WW-1:0] way);
    op(1'b1, s, t, w, pv, pi, pt, way, 1'b0, '0, 1'b0, 1'b0);
  endtask

  task automatic fill(input logic [XW-1:0] idx);
    op(1'b0, '0, '0, 1'b0, '0, '0, '0, '0, 1'b1, idx, 1'b0, 1'b0);
  endtask

  task automatic pop();
    op(1'b0, '0, '0, 1'b0, '0, '0, '0, '0, 1'b0, '0, 1'b1, 1'b0);
  endtask

  task automatic probe(input logic [SW-1:0] s, input logic [TW-1:0] t,
                       input logic exp, input string req);
    lk_set_i = s; lk_tag_i = t;
    #1;
    chk(lk_hit_o == exp, req, "lookup hit", longint'(lk_hit_o), longint'(exp));
  endtask

  task automatic chk_cnt(input string req);
    chk(int'(count_o) == m_cnt, req, "count", longint'(count_o), longint'(m_cnt));
    chk(full_o == (m_cnt == N), req, "full", longint'(full_o), longint'(m_cnt == N));
  endtask

  // Monitor: compares each result the design produces with the next expected item.
  always @(negedge clk) begin
    if (!rst) begin
      if (al_ack_o) begin
        if (q_al.size() == 0) chk(1'b0, "R3", "unexpected alloc ack", 64'd1, 64'd0);
        else begin
          int e;
          e = q_al.pop_front();
          chk(int'(al_idx_o) == e, "R3", "alloc index", longint'(al_idx_o), longint'(e));
        end
      end
      if (up_valid_o) begin
        if (q_up.size() == 0) chk(1'b0, "R5", "unexpected line update", 64'd1, 64'd0);
        else begin
          logic [SW+TW+WW-1:0] e;
          e = q_up.pop_front();
          chk({up_set_o, up_tag_o, up_way_o} == e, "R5", "line update",
              longint'({up_set_o, up_tag_o, up_way_o}), longint'(e));
        end
      end
      if (rp_valid_o) begin
        if (q_rp.size() == 0) chk(1'b0, "R7", "unexpected replay", 64'd1, 64'd0);
        else begin
          logic [SW+TW+PW-1:0] e;
          logic [SW+TW+PW-1:0] a;
          e = q_rp.pop_front();
          a = {rp_set_o, rp_tag_o, rp_write_o, rp_pvld_o, rp_pid_o, rp_ptag_o};
          chk(a == e, "R7", "replay record", longint'(a), longint'(e));
        end
      end
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 0;
    #1;
    // R1: reset state
    chk(count_o == '0, "R1", "count after reset", longint'(count_o), 0);
    chk(!full_o, "R1", "full after reset", longint'(full_o), 0);
    chk(!al_ack_o && !up_valid_o && !rp_valid_o, "R1", "outputs idle after reset",
        longint'({al_ack_o, up_valid_o, rp_valid_o}), 0);
    probe(3'd1, 6'd5, 1'b0, "R1");

    // R3 / R2: first miss lands in entry 0
    alloc(3'd1, 6'd5, 1'b0, 2'b01, {3'd0, 3'd2}, {4'd0, 4'd7}, 2'd1);
    chk(al_ack_o, "R3", "ack after alloc", longint'(al_ack_o), 1);
    chk_cnt("R3");
    probe(3'd1, 6'd5, 1'b1, "R2");
    probe(3'd1, 6'd6, 1'b0, "R2");
    probe(3'd2, 6'd5, 1'b0, "R2");

    // R4: fill the file; entry 3 shares only the tag with entries 0 and 1
    alloc(3'd1, 6'd5, 1'b1, 2'b11, {3'd4, 3'd5}, {4'd3, 4'd9}, 2'd2);
    alloc(3'd3, 6'd9, 1'b0, 2'b10, {3'd6, 3'd0}, {4'd12, 4'd0}, 2'd0);
    alloc(3'd4, 6'd5, 1'b0, 2'b01, {3'd0, 3'd7}, {4'd0, 4'd1}, 2'd3);
    chk_cnt("R4");
    chk(full_o, "R4", "full with all entries used", longint'(full_o), 1);

    // R4: allocation while full is refused
    alloc(3'd6, 6'd1, 1'b0, 2'b01, {3'd0, 3'd1}, {4'd0, 4'd2}, 2'd1);
    chk(!al_ack_o, "R4", "no ack while full", longint'(al_ack_o), 0);
    chk_cnt("R4");

    // R8: pop with nothing ready
    pop();
    chk(!rp_valid_o, "R8", "no replay when none ready", longint'(rp_valid_o), 0);
    chk_cnt("R8");

    // R5: fill releases entry 2; line still occupied until drained
    fill(2'd2);
    chk(up_valid_o, "R5", "update after fill", longint'(up_valid_o), 1);
    probe(3'd3, 6'd9, 1'b1, "R2");

    // R6: second fill on a replay-ready root is ignored
    fill(2'd2);
    chk(!up_valid_o, "R6", "no update for non-waiting root", longint'(up_valid_o), 0);

    // R7: drain entry 2
    pop();
    chk(rp_valid_o, "R7", "replay valid", longint'(rp_valid_o), 1);
    chk_cnt("R7");

    // R5: one fill releases entries 0 and 1, entry 3 stays waiting
    fill(2'd0);
    chk(up_valid_o, "R5", "update for shared line", longint'(up_valid_o), 1);

    // R9: alloc and pop together keep the count; alloc takes entry 2
    op(1'b1, 3'd5, 6'd2, 1'b1, 2'b11, {3'd1, 3'd3}, {4'd5, 4'd6}, 2'd0,
       1'b0, '0, 1'b1, 1'b0);
    chk(al_ack_o && rp_valid_o, "R9", "alloc and pop both taken",
        longint'({al_ack_o, rp_valid_o}), 3);
    chk_cnt("R9");

    // R7: second released entry drains next
    pop();
    chk_cnt("R7");
    probe(3'd4, 6'd5, 1'b1, "R5");

    // R7: fill and pop in one cycle; newly released entry not yet eligible
    op(1'b0, '0, '0, 1'b0, '0, '0, '0, '0, 1'b1, 2'd3, 1'b1, 1'b0);
    chk(!rp_valid_o, "R7", "no same-cycle replay of fresh release", longint'(rp_valid_o), 0);
    chk(up_valid_o, "R5", "update for entry 3", longint'(up_valid_o), 1);
    pop();
    chk(rp_valid_o, "R7", "replay of entry 3", longint'(rp_valid_o), 1);
    chk_cnt("R7");

    // R6: fill naming a free entry is ignored
    fill(2'd0);
    chk(!up_valid_o, "R6", "no update for free root", longint'(up_valid_o), 0);
    chk_cnt("R6");

    // R1: clear empties the file
    op(1'b0, '0, '0, 1'b0, '0, '0, '0, '0, 1'b0, '0, 1'b0, 1'b1);
    chk_cnt("R1");
    probe(3'd5, 6'd2, 1'b0, "R1");

    // R3: allocation after clear restarts at entry 0
    alloc(3'd7, 6'd63, 1'b0, 2'b10, {3'd2, 3'd0}, {4'd15, 4'd0}, 2'd2);
    chk_cnt("R3");

    // R9: clear wins over a same-cycle allocation
    op(1'b1, 3'd2, 6'd3, 1'b0, 2'b01, {3'd0, 3'd1}, {4'd0, 4'd1}, 2'd1,
       1'b0, '0, 1'b0, 1'b1);
    chk(!al_ack_o, "R9", "no ack under clear", longint'(al_ack_o), 0);
    chk_cnt("R9");

    repeat (2) @(negedge clk);
    chk(q_al.size() == 0, "R3", "pending alloc results", longint'(q_al.size()), 0);
    chk(q_up.size() == 0, "R5", "pending updates", longint'(q_up.size()), 0);
    chk(q_rp.size() == 0, "R7", "pending replays", longint'(q_rp.size()), 0);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: actual=expired expected=finished");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
    $finish;
  end

endmodule